// File: doc/BRIEF.md
# Gate Driver Short-Load Fault Controller

This block supervises four low-side gate drive outputs. Each channel takes an enable request from a host and a comparator bit that is high while the drain of its power FET sits above a fault reference. When enabled, the channel drives its gate high. For a fixed number of cycles after every off-to-on gate edge it ignores the comparator, because the drain needs time to settle. After that window it debounces any over-reference reading. A reading that stays high for the full debounce time counts as a confirmed short.

On a confirmed short the steady gate drive stops. The gate then carries a low duty cycle retry train, with a fixed period and a fixed pulse width. Each retry pulse is handled as a fresh turn-on, so it starts with its own blanking window. If, after that window, a pulse sees the drain back below the reference, the channel returns to normal conduction and its fault clears without any host action. Each channel reports its fault on its own bit. One shared active-low flag reports that at least one channel is faulted. All times are parameters counted in clock cycles.

Top module: `gate_fault_ctrl`

## Requirements
- R1: During and after reset, every gate output is low, every fault bit is 0 and the shared flag `fault_any_n_o` is high (inactive).
- R2: When an idle channel sees its enable high at a clock edge, its gate goes high after that edge. For the next BLANK_CYC cycles the drain input of that channel has no effect.
- R3: After blanking, a fault is confirmed only when the synchronised drain bit is high on DEB_CYC consecutive cycles. A shorter high run is discarded and leaves the gate high with the fault bit at 0.
- R4: Once a fault is confirmed, the gate goes low for PERIOD_CYC-PULSE_CYC cycles and then high for PULSE_CYC cycles. This repeats with a period of PERIOD_CYC cycles for as long as the short persists and the enable stays high.
- R5: Bit i of `fault_o` belongs to channel i. It is 1 exactly while that channel is in its retry pulse train, in both the gate-low and the gate-high part.
- R6: `fault_any_n_o` is low exactly when at least one bit of `fault_o` is 1.
- R7: During a retry pulse, once the first BLANK_CYC cycles of that pulse have passed, a synchronised drain bit of 0 clears the channel's fault bit on the next edge. The gate then stays high as in normal conduction.
- R8: A low enable sampled at a clock edge forces that channel's gate low and its fault bit to 0 after that edge, from any state.
- R9: The drain inputs pass through a two-stage synchroniser. A change on `drain_hi_i` takes effect on the channel's decisions two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | NCH | Per-channel enable request from the host |
| drain_hi_i | input | NCH | Per-channel comparator bit, 1 while the drain is above the fault reference |
| gate_o | output | NCH | Per-channel gate drive |
| fault_o | output | NCH | Per-channel short-load fault bit |
| fault_any_n_o | output | 1 | Shared fault flag, active low |

## Verification
The assertions assume the host holds each enable as a level that is sampled once per clock. They also assume the comparator bits may change at any cycle, since the synchroniser absorbs their timing, and that the parameters satisfy PULSE_CYC > BLANK_CYC + DEB_CYC and PERIOD_CYC > PULSE_CYC. The bench uses shortened timing parameters that satisfy these limits. It changes inputs only on the falling clock edge and toggles enables and drain bits across blanking, debounce, retry and clearing phases, so every input pattern stays within those assumptions.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
    typedef enum logic [2:0] {
        CH_OFF        = 3'd0,
        CH_BLANK      = 3'd1,
        CH_ON_MONITOR = 3'd2,
        CH_PWM_ON     = 3'd3,
        CH_PWM_OFF    = 3'd4
    } ch_state_e;
endpackage

// File: rtl/gfc_sync.sv
module gfc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q_o = sync_q.s2;
endmodule

// File: rtl/gfc_channel.sv
module gfc_channel
    import gfc_pkg::*;
#(
    parameter int BLANK_CYC  = 60,
    parameter int DEB_CYC    = 10,
    parameter int PERIOD_CYC = 10000,
    parameter int PULSE_CYC  = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic drain_s_i,
    output logic gate_o,
    output logic fault_o
);
    localparam int CNT_W = $clog2(PERIOD_CYC + 1);
    localparam int DEB_W = $clog2(DEB_CYC + 1);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_END  = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST   = CNT_W'(PERIOD_CYC - PULSE_CYC - 1);
    localparam logic [DEB_W-1:0] DEB_LAST   = DEB_W'(DEB_CYC - 1);

    typedef struct packed {
        ch_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [DEB_W-1:0] deb;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (!en_i) begin
            ch_d.st  = CH_OFF;
            ch_d.cnt = '0;
            ch_d.deb = '0;
        end else begin
            unique case (ch_q.st)
                CH_OFF: begin
                    ch_d.st  = CH_BLANK;
                    ch_d.cnt = '0;
                end
                CH_BLANK: begin
                    if (ch_q.cnt == BLANK_LAST) begin
                        ch_d.st  = CH_ON_MONITOR;
                        ch_d.cnt = '0;
                        ch_d.deb = '0;
                    end else begin
                        ch_d.cnt = ch_q.cnt + 1'b1;
                    end
                end
                CH_ON_MONITOR: begin
                    if (drain_s_i) begin
                        if (ch_q.deb == DEB_LAST) begin
                            ch_d.st  = CH_PWM_OFF;
                            ch_d.cnt = '0;
                            ch_d.deb = '0;
                        end else begin
                            ch_d.deb = ch_q.deb + 1'b1;
                        end
                    end else begin
                        ch_d.deb = '0;
                    end
                end
                CH_PWM_ON: begin
                    if (ch_q.cnt >= BLANK_END && !drain_s_i) begin
                        ch_d.st  = CH_ON_MONITOR;
                        ch_d.cnt = '0;
                        ch_d.deb = '0;
                    end else if (ch_q.cnt == PULSE_LAST) begin
                        ch_d.st  = CH_PWM_OFF;
                        ch_d.cnt = '0;
                    end else begin
                        ch_d.cnt = ch_q.cnt + 1'b1;
                    end
                end
                CH_PWM_OFF: begin
                    if (ch_q.cnt == OFF_LAST) begin
                        ch_d.st  = CH_PWM_ON;
                        ch_d.cnt = '0;
                    end else begin
                        ch_d.cnt = ch_q.cnt + 1'b1;
                    end
                end
                default: begin
                    ch_d.st  = CH_OFF;
                    ch_d.cnt = '0;
                    ch_d.deb = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.st  <= CH_OFF;
            ch_q.cnt <= '0;
            ch_q.deb <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign gate_o  = (ch_q.st == CH_BLANK) || (ch_q.st == CH_ON_MONITOR) ||
                     (ch_q.st == CH_PWM_ON);
    assign fault_o = (ch_q.st == CH_PWM_ON) || (ch_q.st == CH_PWM_OFF);
endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl #(
    parameter int NCH        = 4,
    parameter int BLANK_CYC  = 60,
    parameter int DEB_CYC    = 10,
    parameter int PERIOD_CYC = 10000,
    parameter int PULSE_CYC  = 80
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] drain_hi_i,
    output logic [NCH-1:0] gate_o,
    output logic [NCH-1:0] fault_o,
    output logic           fault_any_n_o
);
    logic [NCH-1:0] drain_s;

    gfc_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (drain_hi_i),
        .q_o   (drain_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gfc_channel #(
            .BLANK_CYC  (BLANK_CYC),
            .DEB_CYC    (DEB_CYC),
            .PERIOD_CYC (PERIOD_CYC),
            .PULSE_CYC  (PULSE_CYC)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_i[i]),
            .drain_s_i (drain_s[i]),
            .gate_o    (gate_o[i]),
            .fault_o   (fault_o[i])
        );
    end

    assign fault_any_n_o = ~(|fault_o);
endmodule

// File: rtl/gate_fault_ctrl_chk.sv
module gate_fault_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] en_i,
    input logic [NCH-1:0] gate_o,
    input logic [NCH-1:0] fault_o,
    input logic           fault_any_n_o
);
    // R8: a channel can only conduct or report if its enable was high at the last edge
    a_r8_gate_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & ~$past(en_i)) == '0);
    a_r8_fault_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o & ~$past(en_i)) == '0);

    // R2: an idle enabled channel is conducting one edge later
    a_r2_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_i & ~gate_o & ~fault_o)) |=>
        ((gate_o & $past(en_i & ~gate_o & ~fault_o)) == $past(en_i & ~gate_o & ~fault_o)));

    // R4: a newly raised fault bit comes with the gate just switched off
    a_r4_fault_rise_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_o & ~$past(fault_o)) & (gate_o | ~$past(gate_o))) == '0);

    // R7: a fault that clears while enabled leaves the gate conducting
    a_r7_clear_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fault_o & $past(fault_o) & $past(en_i) & en_i) & ~gate_o) == '0);

    // R6: shared flag follows the per-channel bits
    a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any_n_o == (fault_o == '0));
endmodule

bind gate_fault_ctrl gate_fault_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .gate_o        (gate_o),
    .fault_o       (fault_o),
    .fault_any_n_o (fault_any_n_o)
);

// File: tb/sim_gate_fault_ctrl.sv
`timescale 1ns/1ps
module sim_gate_fault_ctrl;
    localparam int NCH = 4;
    localparam int BLK = 6;
    localparam int DEB = 3;
    localparam int PER = 40;
    localparam int PUL = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] drain = '0;
    logic [NCH-1:0] gate, fault;
    logic           flag_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    int mode [NCH];   // 0 idle, 1 settling, 2 watching, 3 retry high, 4 retry low
    int tmr  [NCH];
    int hits [NCH];
    bit sa [NCH];
    bit sb [NCH];

    always #10 clk = ~clk;

    gate_fault_ctrl #(
        .NCH(NCH), .BLANK_CYC(BLK), .DEB_CYC(DEB), .PERIOD_CYC(PER), .PULSE_CYC(PUL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .drain_hi_i(drain),
        .gate_o(gate), .fault_o(fault), .fault_any_n_o(flag_n)
    );

    initial begin
        for (int c = 0; c < NCH; c++) begin
            mode[c] = 0; tmr[c] = 0; hits[c] = 0; sa[c] = 0; sb[c] = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                mode[c] = 0; tmr[c] = 0; hits[c] = 0; sa[c] = 0; sb[c] = 0;
            end else begin
                bit seen;
                seen = sb[c];          // R9: value delayed by two edges
                if (!en[c]) begin
                    mode[c] = 0; tmr[c] = 0; hits[c] = 0;
                end else if (mode[c] == 0) begin
                    mode[c] = 1; tmr[c] = 0;
                end else if (mode[c] == 1) begin
                    tmr[c]++;
                    if (tmr[c] == BLK) begin mode[c] = 2; hits[c] = 0; end
                end else if (mode[c] == 2) begin
                    hits[c] = seen ? hits[c] + 1 : 0;
                    if (hits[c] == DEB) begin mode[c] = 4; tmr[c] = 0; hits[c] = 0; end
                end else if (mode[c] == 3) begin
                    if (tmr[c] >= BLK && !seen) begin mode[c] = 2; hits[c] = 0; end
                    else begin
                        tmr[c]++;
                        if (tmr[c] == PUL) begin mode[c] = 4; tmr[c] = 0; end
                    end
                end else begin
                    tmr[c]++;
                    if (tmr[c] == PER - PUL) begin mode[c] = 3; tmr[c] = 0; end
                end
                sb[c] = sa[c];
                sa[c] = drain[c];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            bit any;
            any = 0;
            for (int c = 0; c < NCH; c++) begin
                bit eg, ef;
                eg = (mode[c] == 1) || (mode[c] == 2) || (mode[c] == 3);
                ef = (mode[c] >= 3);
                any |= ef;
                if (mode[c] >= 3)      chk("R4 gate", gate[c], eg);
                else if (mode[c] == 1) chk("R2 gate", gate[c], eg);
                else if (mode[c] == 0) chk("R8 gate", gate[c], eg);
                else                   chk("R3 gate", gate[c], eg);
                chk("R5 fault bit", fault[c], ef);
            end
            chk("R6 flag", flag_n, !any);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        chk("R1 gate", gate, 0);
        chk("R1 fault", fault, 0);
        chk("R1 flag", flag_n, 1);
        rst_n = 1'b1;
        step(2);
        chk("R1 after release", gate, 0);

        // ch0 normal run, drain low
        en[0] = 1'b1;
        step(1);
        chk("R2 turn on", gate[0], 1);
        step(30);
        chk("R2 steady", gate[0], 1);

        // ch1 short present from the start: blanking ignores it, then fault
        drain[1] = 1'b1;
        en[1] = 1'b1;
        step(BLK);
        chk("R2 blank ignores drain", fault[1], 0);
        step(20);
        chk("R3 short confirmed", fault[1], 1);
        step(3 * PER);
        chk("R4 still retrying", fault[1], 1);
        // R7: short removed, next retry pulse clears
        drain[1] = 1'b0;
        step(PER + 5);
        chk("R7 auto clear", fault[1], 0);
        chk("R7 gate conducting", gate[1], 1);

        // ch2 glitch shorter than debounce is discarded
        en[2] = 1'b1;
        step(BLK + 5);
        drain[2] = 1'b1;
        step(DEB - 1);
        drain[2] = 1'b0;
        step(10);
        chk("R3 glitch discarded", fault[2], 0);
        chk("R3 glitch gate", gate[2], 1);
        // R9: exactly DEB cycles high faults
        drain[2] = 1'b1;
        step(DEB);
        drain[2] = 1'b0;
        step(4);
        chk("R9 sync path fault", fault[2], 1);
        step(PER + 2);
        chk("R7 ch2 clears", fault[2], 0);

        // ch3 fault then host disable
        en[3] = 1'b1;
        drain[3] = 1'b1;
        step(BLK + DEB + 6);
        chk("R5 ch3 fault", fault[3], 1);
        chk("R6 flag active", flag_n, 0);
        en[3] = 1'b0;
        step(1);
        chk("R8 disable gate", gate[3], 0);
        chk("R8 disable fault", fault[3], 0);
        drain[3] = 1'b0;
        en[0] = 1'b0;
        step(1);
        chk("R8 ch0 off", gate[0], 0);
        step(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles >= 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule